// File: doc/BRIEF.md
# Request-Driven Glitch-Free Clock Gate

This block sits behind a bank of free-running reference clock outputs and decides, per output, when each one runs and when it stops. Every output can be stopped by its own asynchronous active-low request line, or by a shared stop condition. The shared condition is formed from a global active-low stop pin and a software run bit. Each output has a request-enable bit that arms its request line and a stoppable bit that exposes it to the shared condition. The control bits arrive as plain inputs. An output with neither bit set is never touched.

The reference clock is modelled as a phase that toggles on every edge of `clk_i`, so one reference period is two `clk_i` cycles. A complement edge is a `clk_i` edge at which the true leg falls and the complement leg rises. All sampling of requests and all run/stop decisions happen only on complement edges. An output therefore stops right after its true leg has fallen. It restarts from a complete low phase, so no shortened pulse reaches the pin.

Each output presents a true leg, a complement leg and a drive-valid flag. When the drive-valid flag is 0, the pad is tri-stated.

Top module: `clk_req_gate`

## Requirements
- R1: After reset every output runs: `drv_o` is 1, `clk_c_o` is the inverse of `clk_t_o`, and the true leg toggles on every `clk_i` cycle.
- R2: A request line is passed through a two-stage synchronizer. A level counts only once it has been seen unchanged on two consecutive complement edges, so a one-cycle pulse changes no output.
- R3: When request line i goes high (1 = release, the output is not wanted) and `req_en_i[i]` is 1, output i stops after its next falling true edge with `clk_t_o`=0, `clk_c_o`=0 and `drv_o`=0.
- R4: When request line i goes low again, output i restarts between 4 and 12 `clk_i` cycles (2 to 6 reference periods) later. Its first true high is preceded by one full driven low phase.
- R5: A request line whose `req_en_i` bit is 0 has no effect on its output.
- R6: The shared stop is active when `stop_ni` is 0 or `sw_run_i` is 0 (OR of both). It stops only outputs whose `stoppable_i` bit is 1. An output with both `stoppable_i` and `req_en_i` at 0 keeps running under any stop source.
- R7: Setting `sw_run_i` to 0 stops the stoppable outputs, and setting it back to 1 restarts them.
- R8: An output held by the shared stop is driven with `clk_t_o`=0, `clk_c_o`=1, `drv_o`=1 when `stop_tri_i` is 0. It is undriven with both legs 0 and `drv_o`=0 when `stop_tri_i` is 1. A request-driven stop is always undriven.
- R9: After `stop_ni` returns high, the held stoppable outputs restart within 8 `clk_i` cycles.
- R10: Outputs whose stop conditions clear together restart on the same `clk_i` cycle.
- R11: Bit i of every vector port belongs to output i, and a stop of one output leaves the others running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock, twice the reference output rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_ni | input | N_OUT | Per-output asynchronous request, 0 = clock wanted |
| req_en_i | input | N_OUT | Per-output request enable |
| stoppable_i | input | N_OUT | Per-output exposure to the shared stop |
| stop_ni | input | 1 | Asynchronous global stop, active low |
| sw_run_i | input | 1 | Software run bit, 0 = stop stoppable outputs |
| stop_tri_i | input | 1 | Shared-stop drive mode, 1 = tri-state |
| clk_t_o | output | N_OUT | True leg of each output |
| clk_c_o | output | N_OUT | Complement leg of each output |
| drv_o | output | N_OUT | Drive valid, 0 = pad tri-stated |

## Verification
The bench builds the block with its default four outputs and two synchronizer stages. Four outputs are enough to keep one output free-running, one request-controlled and two stoppable outputs in play at once. That lets R6 and R11 be judged against neighbours that must keep toggling, and lets R10 compare the restart cycle of two outputs released together. Two synchronizer stages keep the restart window short enough that the 4-to-12 cycle bound of R4 and the 8-cycle bound of R9 are checked tightly at both ends.

// File: rtl/cks_pkg.sv
package cks_pkg;
  typedef enum logic [1:0] {
    GS_RUN      = 2'd0,
    GS_HOLD_DRV = 2'd1,
    GS_HOLD_TRI = 2'd2
  } gate_st_e;
endpackage

// File: rtl/cks_sync.sv
module cks_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cks_debounce.sv
module cks_debounce #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         samp_en_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] q_next_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] lvl_q;

  for (genvar b = 0; b < N; b++) begin : g_bit
    // level accepted only when two consecutive complement-edge samples agree
    assign q_next_o[b] = (samp_en_i && (d_i[b] == prev_q[b])) ? d_i[b] : lvl_q[b];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[b] <= 1'b0;
        lvl_q[b]  <= 1'b0;
      end else if (samp_en_i) begin
        prev_q[b] <= d_i[b];
        lvl_q[b]  <= q_next_o[b];
      end
    end

    a_r2_needs_two_samples: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (samp_en_i && (d_i[b] != prev_q[b])) |=> $stable(lvl_q[b]));
  end

  assign q_o = lvl_q;
endmodule

// File: rtl/cks_gate.sv
module cks_gate
  import cks_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ph_i,
  input  logic upd_i,
  input  logic req_stop_i,
  input  logic glb_stop_i,
  input  logic tri_mode_i,
  output logic t_o,
  output logic c_o,
  output logic oe_o
);
  gate_st_e st_q, st_d;

  always_comb begin
    if (req_stop_i)      st_d = GS_HOLD_TRI;
    else if (glb_stop_i) st_d = tri_mode_i ? GS_HOLD_TRI : GS_HOLD_DRV;
    else                 st_d = GS_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= GS_RUN;
    else if (upd_i) st_q <= st_d;
  end

  always_comb begin
    unique case (st_q)
      GS_RUN:      begin t_o = ph_i;  c_o = ~ph_i; oe_o = 1'b1; end
      GS_HOLD_DRV: begin t_o = 1'b0;  c_o = 1'b1;  oe_o = 1'b1; end
      default:     begin t_o = 1'b0;  c_o = 1'b0;  oe_o = 1'b0; end
    endcase
  end

  // state moves only while the phase is in its low half (R3, R4)
  a_r3_change_in_low_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != $past(st_q)) |-> !ph_i);
endmodule

// File: rtl/clk_req_gate.sv
module clk_req_gate #(
  parameter int N_OUT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_OUT-1:0] req_ni,
  input  logic [N_OUT-1:0] req_en_i,
  input  logic [N_OUT-1:0] stoppable_i,
  input  logic             stop_ni,
  input  logic             sw_run_i,
  input  logic             stop_tri_i,
  output logic [N_OUT-1:0] clk_t_o,
  output logic [N_OUT-1:0] clk_c_o,
  output logic [N_OUT-1:0] drv_o
);
  logic             ph_q;
  logic             comp_edge;
  logic [N_OUT-1:0] req_sync;
  logic [N_OUT-1:0] req_lvl;
  logic [N_OUT-1:0] req_lvl_next;
  logic             stop_sync;
  logic             shared_stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ~ph_q;
  end

  // edge at which the true leg falls and the complement leg rises
  assign comp_edge = ph_q;

  cks_sync #(.W(N_OUT), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_req_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_ni),
    .q_o   (req_sync)
  );

  cks_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stop_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (stop_ni),
    .q_o   (stop_sync)
  );

  cks_debounce #(.N(N_OUT)) u_deb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .samp_en_i(comp_edge),
    .d_i      (req_sync),
    .q_o      (req_lvl),
    .q_next_o (req_lvl_next)
  );

  assign shared_stop = ~stop_sync | ~sw_run_i;

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    cks_gate u_gate (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ph_i      (ph_q),
      .upd_i     (comp_edge),
      .req_stop_i(req_en_i[i] & req_lvl_next[i]),
      .glb_stop_i(stoppable_i[i] & shared_stop),
      .tri_mode_i(stop_tri_i),
      .t_o       (clk_t_o[i]),
      .c_o       (clk_c_o[i]),
      .oe_o      (drv_o[i])
    );

    a_r4_full_low_before_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(clk_t_o[i]) |-> $past(drv_o[i] && clk_c_o[i]));

    a_r6_free_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stoppable_i[i] && !req_en_i[i] && ph_q) |=> (drv_o[i] && clk_c_o[i]));

    a_r8_undriven_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !drv_o[i] |-> (!clk_t_o[i] && !clk_c_o[i]));

    a_r3_request_stop_undriven: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ph_q && req_en_i[i] && req_lvl_next[i]) |=> !drv_o[i]);
  end

  a_r2_level_follows_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !comp_edge |=> $stable(req_lvl));
endmodule

// File: tb/clk_req_gate_test.sv
`timescale 1ns/1ps
module clk_req_gate_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] req_ni = '0;
  logic [N-1:0] req_en_i = '0;
  logic [N-1:0] stoppable_i = '0;
  logic         stop_ni = 1'b1;
  logic         sw_run_i = 1'b1;
  logic         stop_tri_i = 1'b0;
  logic [N-1:0] clk_t_o, clk_c_o, drv_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  clk_req_gate #(.N_OUT(N), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_ni(req_ni), .req_en_i(req_en_i),
    .stoppable_i(stoppable_i), .stop_ni(stop_ni), .sw_run_i(sw_run_i),
    .stop_tri_i(stop_tri_i), .clk_t_o(clk_t_o), .clk_c_o(clk_c_o), .drv_o(drv_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // two consecutive samples: driven, complementary, toggling
  task automatic check_running(input int i, input string req);
    logic t0;
    step(1);
    t0 = clk_t_o[i];
    check(drv_o[i] && (clk_t_o[i] != clk_c_o[i]), req, int'(drv_o[i]), 1);
    step(1);
    check(drv_o[i] && (clk_t_o[i] != t0), req, int'(clk_t_o[i]), int'(~t0));
  endtask

  task automatic check_held(input int i, input bit drv, input string req);
    int bad = 0;
    for (int k = 0; k < 4; k++) begin
      step(1);
      if (drv_o[i] != drv || clk_t_o[i] != 1'b0 || clk_c_o[i] != drv) bad++;
    end
    check(bad == 0, req, int'({drv_o[i], clk_t_o[i], clk_c_o[i]}), int'({drv, 1'b0, drv}));
  endtask

  task automatic measure_rise(input int a, input int b, output int la, output int lb);
    la = -1; lb = -1;
    for (int k = 1; k <= 40; k++) begin
      step(1);
      if (la < 0 && clk_t_o[a]) la = k;
      if (lb < 0 && clk_t_o[b]) lb = k;
      if (la >= 0 && lb >= 0) break;
    end
  endtask

  task automatic t_reset;
    step(1);
    check(drv_o == '1, "R1 drive after reset", int'(drv_o), 15);
    check((clk_t_o ^ clk_c_o) == '1, "R1 complementary legs", int'(clk_t_o ^ clk_c_o), 15);
    check_running(3, "R1 toggling");
  endtask

  task automatic t_request_stop_resume;
    int la, lb;
    req_en_i[0] = 1'b1;
    req_ni[0]   = 1'b1;
    step(14);
    check_held(0, 1'b0, "R3 request stop undriven low");
    check_running(1, "R11 neighbour keeps running");
    req_ni[0] = 1'b0;
    measure_rise(0, 0, la, lb);
    check(la >= 4 && la <= 12, "R4 resume latency", la, 8);
    step(1);
    check(!clk_t_o[0] && clk_c_o[0] && drv_o[0], "R4 full-width pulse", int'(clk_t_o[0]), 0);
    req_en_i[0] = 1'b0;
  endtask

  task automatic t_short_pulse;
    int bad = 0;
    req_en_i[1] = 1'b1;
    step(3);
    req_ni[1] = 1'b1;
    step(1);
    req_ni[1] = 1'b0;
    for (int k = 0; k < 16; k++) begin
      step(1);
      if (!drv_o[1]) bad++;
    end
    check(bad == 0, "R2 one-cycle pulse ignored", bad, 0);
    req_en_i[1] = 1'b0;
  endtask

  task automatic t_disabled_request;
    int bad = 0;
    req_ni[2] = 1'b1;
    for (int k = 0; k < 20; k++) begin
      step(1);
      if (!drv_o[2]) bad++;
    end
    check(bad == 0, "R5 disabled request ignored", bad, 0);
    check_running(2, "R5 still toggling");
    req_ni[2] = 1'b0;
    step(4);
  endtask

  task automatic t_global_stop;
    int la, lb;
    stoppable_i = 4'b0011;
    stop_tri_i  = 1'b0;
    stop_ni     = 1'b0;
    step(10);
    check_held(0, 1'b1, "R8 driven hold out0");
    check_held(1, 1'b1, "R8 driven hold out1");
    check_running(2, "R6 non-stoppable runs");
    check_running(3, "R6 non-stoppable runs");
    stop_tri_i = 1'b1;
    step(4);
    check_held(0, 1'b0, "R8 tri-state hold");
    stop_ni = 1'b1;
    measure_rise(0, 1, la, lb);
    check(la >= 1 && la <= 8, "R9 release latency", la, 5);
    check(la == lb, "R10 same restart cycle", lb, la);
    stoppable_i = '0;
    stop_tri_i  = 1'b0;
  endtask

  task automatic t_sw_stop;
    stoppable_i = 4'b0100;
    stop_tri_i  = 1'b1;
    sw_run_i    = 1'b0;
    step(10);
    check_held(2, 1'b0, "R7 software stop");
    check_running(3, "R7 others run");
    sw_run_i = 1'b1;
    step(10);
    check_running(2, "R7 software resume");
    stoppable_i = '0;
    stop_tri_i  = 1'b0;
  endtask

  task automatic t_joint_release;
    int la, lb;
    req_en_i = 4'b1001;
    req_ni   = 4'b1001;
    step(14);
    check(drv_o[0] == 1'b0 && drv_o[3] == 1'b0, "R3 both stopped", int'(drv_o), 6);
    req_ni = '0;
    measure_rise(0, 3, la, lb);
    check(la == lb, "R10 joint request restart", lb, la);
    check(la >= 4 && la <= 12, "R4 joint latency", la, 8);
    req_en_i = '0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(2);
    t_reset();
    t_request_stop_resume();
    t_short_pulse();
    t_disabled_request();
    t_global_stop();
    t_sw_stop();
    t_joint_release();
    finish_run();
  end

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule